// File: doc/BRIEF.md
# Sticky Fault Status Register with Alert

This block gathers single-cycle fault event pulses from the detectors of a power controller into an 8-bit status register. Once a bit is set it stays set until the host clears it on purpose. While any bit is set, an active-low alert line is driven low so that it can pull down a shared, wired-AND interrupt wire. The line is released only when every bit has been cleared.

The host reaches the block through a simple transaction-level request port. That port is fed by the serial bus layer, which lives outside this block. Each request carries a 7-bit target address, a read/write flag, a command byte and a data byte.

The block supports three operations at its own address:
- Reading the status command returns the register contents.
- Writing the status command clears every bit written as 1.
- A clear-all command empties the whole register in one cycle.

A read to the shared alert response address is answered with the device's own address, but only while this device is pulling the alert line low. The status register stays readable whatever the power stage is doing, including latch-off or hiccup recovery. Dropping the enable input, or a power-on reset, wipes the register and blocks all access.

Top module: `fault_latch_alert`

## Requirements
- R1: A 1 on `faultPulse[i]` while enabled sets status bit i at the next rising clock edge.
- R2: A status bit never returns to 0 except through R3, R5 or R10. Status reads, alert response reads, unknown commands and requests to other addresses leave it unchanged.
- R3: A write to command 0xD0 at the device address clears exactly the status bits whose `reqData` bit is 1. Bits written as 0 keep their value.
- R4: When a fault pulse and a clear (R3 or R5) act on the same bit in the same cycle, the fault wins and the bit is 1 afterwards.
- R5: A write of command 0x03 at the device address zeroes the whole status register at the next edge, whatever `reqData` holds.
- R6: `alertN` is 0 exactly when at least one status bit is 1. It is 1 after reset.
- R7: A read of command 0xD0 at the device address gives `respValid`=1 one cycle later. `respData` then holds the status value as it stood in the request cycle.
- R8: A read at address 0x0C returns `respValid`=1 with `respData` = {DEV_ADDR, 1'b1} one cycle later if `alertN` was 0 in the request cycle. Otherwise `respValid` stays 0. Such a read does not release `alertN`.
- R9: Requests to any other address, and requests at the device address with any other command or direction, produce no response.
- R10: While `enable` is 0, the status register is held at 0, fault pulses and requests are ignored, `respValid` is 0 and `alertN` is 1. `rstN`=0 does the same asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| enable | input | 1 | Device enable; low clears everything and blocks access |
| faultPulse | input | STATUS_W | One single-cycle pulse line per fault source |
| reqValid | input | 1 | A host request is present this cycle |
| reqRead | input | 1 | 1 = read request, 0 = write request |
| reqAddr | input | 7 | Target 7-bit bus address |
| reqCmd | input | 8 | Command byte |
| reqData | input | 8 | Write data byte |
| respValid | output | 1 | Response byte valid (one cycle after a recognised read) |
| respData | output | 8 | Response byte |
| alertN | output | 1 | Active-low alert, low while any status bit is set |

## Verification
Isolated fault pulses on different bits show that each source lands in its own bit and that bits accumulate. Partial clear masks separate write-one-to-clear behaviour from a plain overwrite. Faults placed in the same cycle as a clear, a clear-all or a status read tell apart fault priority and pre-update read timing. Alert response reads made with the alert both asserted and released, together with foreign addresses, unknown commands and traffic while disabled, show that nothing but a proper clear changes state. A long stretch of mixed random traffic is then compared against a behavioural model on every clock.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;

  localparam int BUS_W = 8;
  localparam int ADDR_W = 7;

  localparam logic [BUS_W-1:0]  CMD_STATUS      = 8'hD0;
  localparam logic [BUS_W-1:0]  CMD_CLEAR_ALL   = 8'h03;
  localparam logic [ADDR_W-1:0] ALERT_RESP_ADDR = 7'h0C;

  // Decoded one-hot actions handed from control to datapath
  typedef struct packed {
    logic w1c;       // write-one-to-clear of the status register
    logic clrAll;    // clear-all command
    logic rdStatus;  // status register read
    logic rdAra;     // alert response address read
  } strobe_t;

endpackage

// File: rtl/fault_latch_ctrl.sv
module fault_latch_ctrl
  import fault_latch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqCmd,
  output strobe_t           strb
);

  logic live;
  logic toDevice;
  logic toAra;

  assign live     = enable & reqValid;
  assign toDevice = live & (reqAddr == DEV_ADDR);
  assign toAra    = live & (reqAddr == ALERT_RESP_ADDR);

  always_comb begin
    strb = '0;
    if (toDevice) begin
      if (reqRead) begin
        strb.rdStatus = (reqCmd == CMD_STATUS);
      end else begin
        strb.w1c    = (reqCmd == CMD_STATUS);
        strb.clrAll = (reqCmd == CMD_CLEAR_ALL);
      end
    end else if (toAra) begin
      strb.rdAra = reqRead;
    end
  end

  // R9: a request to a foreign address yields no action
  a_r9_foreign_addr: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr != DEV_ADDR && reqAddr != ALERT_RESP_ADDR) |-> (strb == '0));

  // R10: nothing is decoded while disabled
  a_r10_no_strobe_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (strb == '0));

endmodule

// File: rtl/fault_latch_dp.sv
module fault_latch_dp
  import fault_latch_pkg::*;
#(
  parameter int                STATUS_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  strobe_t             strb,
  input  logic [STATUS_W-1:0] faultPulse,
  input  logic [STATUS_W-1:0] clrMask,
  output logic                respValid,
  output logic [BUS_W-1:0]    respData,
  output logic                alertN
);

  localparam logic [BUS_W-1:0] ARA_BYTE = {DEV_ADDR, 1'b1};

  logic [STATUS_W-1:0] statusQ;
  logic                anySet;

  // One sticky flop per fault source
  for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
    logic clrBit;
    assign clrBit = strb.clrAll | (strb.w1c & clrMask[b]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ[b] <= 1'b0;
      end else if (!enable) begin
        statusQ[b] <= 1'b0;
      end else begin
        statusQ[b] <= faultPulse[b] | (statusQ[b] & ~clrBit);
      end
    end
  end

  assign anySet = |statusQ;
  assign alertN = ~anySet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else if (!enable) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else if (strb.rdStatus) begin
      respValid <= 1'b1;
      respData  <= BUS_W'(statusQ);
    end else if (strb.rdAra && anySet) begin
      respValid <= 1'b1;
      respData  <= ARA_BYTE;
    end else begin
      respValid <= 1'b0;
      respData  <= '0;
    end
  end

  // R1: every pulsed bit is set one edge later
  a_r1_fault_sets: assert property (@(posedge clk) disable iff (!rstN)
    (enable && |faultPulse) |=> ((statusQ & $past(faultPulse)) == $past(faultPulse)));

  // R2: without a clear, no set bit drops
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strb.w1c && !strb.clrAll) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R5: clear-all with no concurrent fault empties the register
  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strb.clrAll && faultPulse == '0) |=> (statusQ == '0));

  // R6: the alert only releases after a clear or a disable
  a_r6_release_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alertN) |-> $past(strb.w1c || strb.clrAll || !enable));

  // R8: no alert response while the alert was released
  a_r8_ara_needs_alert: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdAra && alertN) |=> !respValid);

  // R10: disabled means empty and silent
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (statusQ == '0 && !respValid));

endmodule

// File: rtl/fault_latch_alert.sv
module fault_latch_alert
  import fault_latch_pkg::*;
#(
  parameter int                STATUS_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [STATUS_W-1:0] faultPulse,
  input  logic                reqValid,
  input  logic                reqRead,
  input  logic [6:0]          reqAddr,
  input  logic [7:0]          reqCmd,
  input  logic [7:0]          reqData,
  output logic                respValid,
  output logic [7:0]          respData,
  output logic                alertN
);

  strobe_t strb;

  fault_latch_ctrl #(
    .DEV_ADDR(DEV_ADDR)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .reqValid(reqValid),
    .reqRead (reqRead),
    .reqAddr (reqAddr),
    .reqCmd  (reqCmd),
    .strb    (strb)
  );

  fault_latch_dp #(
    .STATUS_W(STATUS_W),
    .DEV_ADDR(DEV_ADDR)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .strb      (strb),
    .faultPulse(faultPulse),
    .clrMask   (reqData[STATUS_W-1:0]),
    .respValid (respValid),
    .respData  (respData),
    .alertN    (alertN)
  );

endmodule

// File: tb/test_fault_latch_alert.sv
module test_fault_latch_alert;

  localparam logic [6:0] DEV = 7'h40;
  localparam logic [6:0] ARA = 7'h0C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] faultPulse = '0;
  logic       reqValid = 1'b0;
  logic       reqRead = 1'b0;
  logic [6:0] reqAddr = '0;
  logic [7:0] reqCmd = '0;
  logic [7:0] reqData = '0;
  logic       respValid;
  logic [7:0] respData;
  logic       alertN;

  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  done = 0;
  logic       lastV;
  logic [7:0] lastD;

  // behavioural reference state
  logic [7:0] mStatus = '0;
  logic       mRespV = 1'b0;
  logic [7:0] mRespD = '0;

  fault_latch_alert #(.STATUS_W(8), .DEV_ADDR(DEV)) i_fault_latch_alert (
    .clk(clk), .rstN(rstN), .enable(enable), .faultPulse(faultPulse),
    .reqValid(reqValid), .reqRead(reqRead), .reqAddr(reqAddr),
    .reqCmd(reqCmd), .reqData(reqData),
    .respValid(respValid), .respData(respData), .alertN(alertN)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, updated at each edge from the sampled inputs
  always @(posedge clk or negedge rstN) begin
    if (!rstN || !enable) begin
      mStatus = '0;
      mRespV  = 1'b0;
      mRespD  = '0;
    end else begin
      logic [7:0] clr;
      clr = '0;
      mRespV = 1'b0;
      mRespD = '0;
      if (reqValid && reqAddr == DEV) begin
        if (!reqRead && reqCmd == 8'hD0) clr = reqData;
        if (!reqRead && reqCmd == 8'h03) clr = 8'hFF;
        if (reqRead && reqCmd == 8'hD0) begin
          mRespV = 1'b1;
          mRespD = mStatus;
        end
      end else if (reqValid && reqAddr == ARA && reqRead && mStatus != 0) begin
        mRespV = 1'b1;
        mRespD = {DEV, 1'b1};
      end
      mStatus = (mStatus & ~clr) | faultPulse;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check(respValid === mRespV, "R7 R8 R9 model respValid", respValid, mRespV);
      if (mRespV) check(respData === mRespD, "R7 R8 model respData", respData, mRespD);
      check(alertN === (mStatus == 0), "R6 model alertN", alertN, (mStatus == 0));
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      summary();
      $finish;
    end
  end

  // one clock of stimulus; inputs are driven just after a falling edge
  task automatic cyc(input logic [7:0] f, input bit v, input bit rd,
                     input logic [6:0] a, input logic [7:0] c, input logic [7:0] d);
    faultPulse = f; reqValid = v; reqRead = rd; reqAddr = a; reqCmd = c; reqData = d;
    @(negedge clk);
    lastV = respValid;
    lastD = respData;
    faultPulse = '0; reqValid = 1'b0; reqRead = 1'b0; reqAddr = '0; reqCmd = '0; reqData = '0;
  endtask

  task automatic readStatus(input logic [7:0] exp, input string tag);
    cyc('0, 1, 1, DEV, 8'hD0, '0);
    check(lastV === 1'b1, {tag, " respValid"}, lastV, 1);
    check(lastD === exp, {tag, " status"}, lastD, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(alertN === 1'b1 && respValid === 1'b0, "R6 reset alert/resp", {alertN, respValid}, 2'b10);
    rstN = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    readStatus(8'h00, "R10 reset status");

    cyc(8'h05, 0, 0, '0, '0, '0);
    check(alertN === 1'b0, "R6 alert after fault", alertN, 0);
    readStatus(8'h05, "R1 two bits");
    cyc(8'h80, 0, 0, '0, '0, '0);
    readStatus(8'h85, "R1 accumulate");
    readStatus(8'h85, "R2 read keeps");

    cyc('0, 1, 1, ARA, '0, '0);
    check(lastV === 1'b1 && lastD === 8'h81, "R8 ara answer", {lastV, lastD}, {1'b1, 8'h81});
    check(alertN === 1'b0, "R8 ara keeps alert", alertN, 0);

    cyc('0, 1, 0, DEV, 8'h55, 8'hFF);
    cyc('0, 1, 0, 7'h41, 8'hD0, 8'hFF);
    cyc('0, 1, 1, DEV, 8'h55, '0);
    check(lastV === 1'b0, "R9 unknown cmd read", lastV, 0);
    cyc('0, 1, 1, DEV, 8'h03, '0);
    check(lastV === 1'b0, "R9 clear-all as read", lastV, 0);
    readStatus(8'h85, "R2 R9 no change");

    cyc('0, 1, 0, DEV, 8'hD0, 8'h04);
    readStatus(8'h81, "R3 partial w1c");
    cyc(8'h01, 1, 0, DEV, 8'hD0, 8'h81);
    readStatus(8'h01, "R4 fault beats w1c");

    cyc('0, 1, 0, DEV, 8'h03, 8'h00);
    check(alertN === 1'b1, "R5 R6 release after clear-all", alertN, 1);
    readStatus(8'h00, "R5 clear-all");
    cyc('0, 1, 1, ARA, '0, '0);
    check(lastV === 1'b0, "R8 ara silent when idle", lastV, 0);

    cyc(8'h10, 1, 0, DEV, 8'h03, 8'h5A);
    readStatus(8'h10, "R4 fault beats clear-all");
    cyc('0, 1, 0, DEV, 8'hD0, 8'h10);
    check(alertN === 1'b1, "R6 release after w1c", alertN, 1);

    cyc(8'h02, 1, 1, DEV, 8'hD0, '0);
    check(lastV === 1'b1 && lastD === 8'h00, "R7 read shows pre-update", lastD, 0);
    readStatus(8'h02, "R7 then updated");

    cyc(8'h20, 0, 0, '0, '0, '0);
    enable = 1'b0;
    cyc(8'h08, 1, 1, DEV, 8'hD0, '0);
    check(lastV === 1'b0, "R10 no access disabled", lastV, 0);
    check(alertN === 1'b1, "R10 alert released disabled", alertN, 1);
    enable = 1'b1;
    readStatus(8'h00, "R10 lost on disable");

    cyc(8'h40, 0, 0, '0, '0, '0);
    #1 rstN = 1'b0;
    @(negedge clk);
    check(alertN === 1'b1, "R10 async reset alert", alertN, 1);
    #1 rstN = 1'b1;
    @(negedge clk);
    readStatus(8'h00, "R10 lost on reset");

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] f;
      op = $urandom_range(0, 7);
      f  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      case (op)
        0, 1: cyc(f, 1, 1, DEV, 8'hD0, '0);
        2:    cyc(f, 1, 1, ARA, '0, '0);
        3, 4: cyc(f, 1, 0, DEV, 8'hD0, 8'($urandom));
        5:    cyc(f, 1, 0, DEV, 8'h03, 8'($urandom));
        6:    cyc(f, 1, $urandom_range(0, 1) == 1, 7'($urandom), 8'($urandom), 8'($urandom));
        default: cyc(f, 0, 0, '0, '0, '0);
      endcase
    end

    done = 1;
    summary();
    $finish;
  end

endmodule